// File: doc/BRIEF.md
# Preemptive Exception Priority Controller

This block decides which of five fixed exception sources a processor core is servicing at any moment. Each source raises a request bit. The block latches the request as pending, compares it with the handler that is running, and either switches to it at once or holds it back. Priorities are fixed numbers, and a smaller number means a more urgent source. Ties never interrupt.

When a handler is interrupted, its identity goes onto an internal stack of preempted handlers. The core pulses `done` when the running handler finishes. The block then resumes the most recently preempted handler. If a pending request is more urgent than the handler that would resume, the block takes that request first. When nothing is pending and nothing was preempted, the block returns to thread execution and drops `act_valid`. The host only drives request bits and the completion pulse. It reads back the active code, its priority and a one-cycle preemption marker.

Top module: `exc_prio_ctrl`

## Requirements
- R1: A synchronous reset clears all pending requests and the stack of preempted handlers, and leaves `act_valid` and `preempt` low. Requests presented while reset is high are forgotten.
- R2: Source codes map to priorities as follows: code 0 → 0, code 1 → 1, code 2 → 2, code 3 → 3, code 4 → 15. Request bit i belongs to code i. While `act_valid` is high, `act_prio` equals the priority of `act_id`.
- R3: With no active handler, a request sampled at a clock edge becomes active at that same edge, without a `preempt` pulse.
- R4: Among requests that arrive together or are already pending, the one with the smallest priority number is serviced first.
- R5: A request whose priority number is strictly smaller than that of the active handler takes over at the edge where it is sampled, and `preempt` is high for exactly that one cycle.
- R6: A request with an equal or larger priority number leaves the active handler and `preempt` unchanged. This includes a repeat of the running source. The request stays pending.
- R7: On `done`, the most recently preempted handler resumes, so nested handlers return in last-in, first-out order.
- R8: On `done`, a pending request that is more urgent than the handler that would resume is taken first. The resumed handler stays preempted. A pending request that is less urgent waits until every more urgent handler has finished.
- R9: On `done`, with no pending request and no preempted handler, `act_valid` goes low at that edge.
- R10: A source that is requested again while already pending is serviced only once.
- R11: A `done` pulse while no handler is active has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 5 | Request bit for each source, bit i for code i |
| done | input | 1 | One-cycle pulse: the active handler has finished |
| act_valid | output | 1 | A handler is active |
| act_id | output | 3 | Code of the active source |
| act_prio | output | 4 | Priority number of the active source |
| preempt | output | 1 | One-cycle pulse: the previous active handler was interrupted |

## Verification
The bench targets the following corner cases, with the fault each one exposes:
- A repeat of the running source, and a less urgent request arriving during a handler. A design that compared with less-than-or-equal would preempt in both cases and emit a spurious pulse.
- Several levels of nesting unwound one `done` at a time. A design with a queue in place of a stack would resume the wrong handler.
- A `done` that exposes a preempted handler while a request of middle urgency is pending. A design that always popped would run the less urgent handler first. A design that double-counted a repeated request would service it twice.
- `done` pulses given while idle. A design that acted on them would underflow its stack.

// File: rtl/exc_prio_ctrl.sv
module exc_prio_ctrl #(
  parameter int NSRC  = 5,
  parameter int DEPTH = 5,
  parameter int IDW   = 3,
  parameter int PW    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            done,
  output logic            act_valid,
  output logic [IDW-1:0]  act_id,
  output logic [PW-1:0]   act_prio,
  output logic            preempt
);
  localparam int SPW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] prio_of(input logic [IDW-1:0] id);
    case (id)
      IDW'(0):  prio_of = PW'(0);
      IDW'(1):  prio_of = PW'(1);
      IDW'(2):  prio_of = PW'(2);
      IDW'(3):  prio_of = PW'(3);
      default:  prio_of = PW'(15);
    endcase
  endfunction

  logic [NSRC-1:0] pend, cand, take_mask;
  logic [IDW-1:0]  stk [DEPTH];
  logic [SPW-1:0]  sp;
  logic [IDW-1:0]  best_id, top_id;
  logic            best_v, take, push, pop, go_idle;

  assign cand     = pend | req;
  assign act_prio = prio_of(act_id);
  assign top_id   = (sp != '0) ? stk[sp - 1'b1] : '0;

  always_comb begin
    best_v  = 1'b0;
    best_id = '0;
    for (int i = 0; i < NSRC; i++)
      if (cand[i] && (!best_v || prio_of(IDW'(i)) < prio_of(best_id))) begin
        best_v  = 1'b1;
        best_id = IDW'(i);
      end
  end

  always_comb begin
    take    = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    go_idle = 1'b0;
    if (act_valid && done) begin
      if (best_v && (sp == '0 || prio_of(best_id) < prio_of(top_id))) take = 1'b1;
      else if (sp != '0) pop = 1'b1;
      else go_idle = 1'b1;
    end else if (act_valid) begin
      if (best_v && prio_of(best_id) < act_prio) begin
        take = 1'b1;
        push = 1'b1;
      end
    end else if (best_v) begin
      take = 1'b1;
    end
  end

  assign take_mask = take ? (NSRC'(1) << best_id) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      sp        <= '0;
      act_valid <= 1'b0;
      act_id    <= '0;
      preempt   <= 1'b0;
    end else begin
      pend    <= cand & ~take_mask;
      preempt <= push;
      if (push) begin
        stk[sp] <= act_id;
        sp      <= sp + 1'b1;
      end
      if (pop) begin
        act_id <= top_id;
        sp     <= sp - 1'b1;
      end
      if (take) begin
        act_valid <= 1'b1;
        act_id    <= best_id;
      end
      if (go_idle) act_valid <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> sp < SPW'(DEPTH)); // R7
  AST_VALID_CODE: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> act_id < IDW'(NSRC)); // R2
  AST_IDLE_TAKE: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && (req != '0)) |=> act_valid && !preempt); // R3
  AST_PREEMPT_URGENT: assert property (@(posedge clk) disable iff (rst)
    preempt |-> act_valid && act_prio < $past(act_prio)); // R5
  AST_NO_WEAKER: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !done) |=> act_valid && act_prio <= $past(act_prio)); // R6
  AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (act_valid && done && sp == '0 && cand == '0) |=> !act_valid); // R9
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && done && req == '0) |=> !act_valid && $stable(sp)); // R11
endmodule

// File: tb/exc_prio_ctrl_test.sv
`timescale 1ns/1ps
module exc_prio_ctrl_test;
  logic clk = 1'b0, rst = 1'b1, done = 1'b0;
  logic [4:0] req = '0;
  logic act_valid, preempt;
  logic [2:0] act_id;
  logic [3:0] act_prio;
  int checks = 0, fails = 0;

  localparam logic [4:0] S0 = 5'b00001, S1 = 5'b00010, S2 = 5'b00100,
                         S3 = 5'b01000, S4 = 5'b10000;

  always #10 clk = ~clk;

  exc_prio_ctrl uut (.clk(clk), .rst(rst), .req(req), .done(done),
    .act_valid(act_valid), .act_id(act_id), .act_prio(act_prio), .preempt(preempt));

  function automatic int pr(input int id);
    return (id == 4) ? 15 : id;
  endfunction

  task automatic cyc(input logic [4:0] r, input logic d);
    req = r; done = d;
    @(negedge clk);
    req = '0; done = 1'b0;
  endtask

  task automatic expect_st(input string tag, input bit v, input int id, input bit p);
    checks++;
    if (act_valid !== v || preempt !== p || (v && (act_id !== id || act_prio !== pr(id)))) begin
      fails++;
      $display("FAIL %s: got v=%0d id=%0d pr=%0d pre=%0d, exp v=%0d id=%0d pr=%0d pre=%0d",
               tag, act_valid, act_id, act_prio, preempt, v, id, pr(id), p);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(S3, 1'b0);
    expect_st("R1 in reset", 0, 0, 0);
    rst = 1'b0;
    cyc('0, 1'b0);
    expect_st("R1 request during reset forgotten", 0, 0, 0);
  endtask

  task automatic t_idle_take;
    cyc(S3, 1'b0);  expect_st("R3 idle take code3 / R2 prio", 1, 3, 0);
    cyc('0, 1'b1);  expect_st("R9 return to thread", 0, 0, 0);
  endtask

  task automatic t_simul;
    cyc(S3 | S1 | S4, 1'b0); expect_st("R4 most urgent first", 1, 1, 0);
    cyc('0, 1'b1);  expect_st("R4 next pending", 1, 3, 0);
    cyc('0, 1'b1);  expect_st("R2 code4 prio15", 1, 4, 0);
    cyc('0, 1'b1);  expect_st("R9 idle", 0, 0, 0);
  endtask

  task automatic t_nest;
    cyc(S4, 1'b0);  expect_st("R3 take code4", 1, 4, 0);
    cyc(S2, 1'b0);  expect_st("R5 preempt by code2", 1, 2, 1);
    cyc('0, 1'b0);  expect_st("R5 pulse one cycle", 1, 2, 0);
    cyc(S0, 1'b0);  expect_st("R5 preempt by code0", 1, 0, 1);
    cyc('0, 1'b1);  expect_st("R7 resume code2", 1, 2, 0);
    cyc('0, 1'b1);  expect_st("R7 resume code4", 1, 4, 0);
    cyc('0, 1'b1);  expect_st("R9 idle after unwind", 0, 0, 0);
  endtask

  task automatic t_tie;
    cyc(S3, 1'b0);  expect_st("R3 take code3", 1, 3, 0);
    cyc(S3, 1'b0);  expect_st("R6 same source no preempt", 1, 3, 0);
    cyc(S4, 1'b0);  expect_st("R6 less urgent no preempt", 1, 3, 0);
    cyc('0, 1'b1);  expect_st("R6 repeat served after done", 1, 3, 0);
    cyc('0, 1'b1);  expect_st("R6 less urgent served last", 1, 4, 0);
    cyc('0, 1'b1);  expect_st("R9 idle", 0, 0, 0);
  endtask

  task automatic t_resume_pending;
    cyc(S4, 1'b0);  expect_st("R8 setup code4", 1, 4, 0);
    cyc(S2, 1'b0);  expect_st("R8 preempt code2", 1, 2, 1);
    cyc(S3, 1'b0);  expect_st("R8 code3 waits", 1, 2, 0);
    cyc('0, 1'b1);  expect_st("R8 pending beats resumed", 1, 3, 0);
    cyc('0, 1'b1);  expect_st("R8 resumed after", 1, 4, 0);
    cyc('0, 1'b1);  expect_st("R9 idle", 0, 0, 0);
  endtask

  task automatic t_once;
    cyc(S3, 1'b0);  expect_st("R10 setup", 1, 3, 0);
    cyc(S4, 1'b0);  cyc(S4, 1'b0);
    expect_st("R10 still code3", 1, 3, 0);
    cyc('0, 1'b1);  expect_st("R10 code4 once", 1, 4, 0);
    cyc('0, 1'b1);  expect_st("R10 not served twice", 0, 0, 0);
  endtask

  task automatic t_idle_done;
    cyc('0, 1'b1);  cyc('0, 1'b1);
    expect_st("R11 done while idle", 0, 0, 0);
    cyc(S2, 1'b0);  expect_st("R11 normal after idle done", 1, 2, 0);
    cyc(S1, 1'b0);  expect_st("R11 preempt works", 1, 1, 1);
    cyc('0, 1'b1);  expect_st("R11 resume", 1, 2, 0);
    cyc('0, 1'b1);  expect_st("R11 idle", 0, 0, 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle_take();
    t_simul();
    t_nest();
    t_tie();
    t_resume_pending();
    t_once();
    t_idle_done();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule